// File: doc/BRIEF.md
# Column-Compression Integer Multiplier

This block multiplies an `A_W`-bit operand by a `B_W`-bit operand and returns the full `A_W+B_W`-bit product. Both operands are sign- or zero-extended to the product width and an AND-gate array forms the partial products. A column reducer then compresses the array until each bit column holds no more than two bits. The reducer uses half adders, full adders and, when the build option is on, 4:2 cells that pass a horizontal carry to the next column. The two rows that remain are added by a ripple carry-propagate adder.

Each operand has its own signedness. A parameter can fix it, or a per-operand select input can choose it at runtime. When the select is enabled, the static parameter must be left at unsigned. A build parameter can add one register stage between the reducer and the final adder. That stage has an enable and an active-low asynchronous reset. With the stage left out, the block is purely combinational.

Top module: `cmul_top`

## Requirements
- R1: `prod_o` equals `a_i * b_i` modulo 2^(A_W+B_W). Each operand is read as two's complement when its effective signedness is 1 and as unsigned when it is 0. This holds for all four signedness combinations.
- R2: With `A_SEL_EN=1`, `a_sgn_i` gives the signedness of `a_i` (1 = signed). With `A_SEL_EN=0`, the parameter `A_SIGNED` gives it and `a_sgn_i` has no effect on `prod_o`.
- R3: With `B_SEL_EN=1`, `b_sgn_i` gives the signedness of `b_i` (1 = signed). With `B_SEL_EN=0`, the parameter `B_SIGNED` gives it and `b_sgn_i` has no effect on `prod_o`.
- R4: A build with `USE_42=1` (4:2 cells mixed with 3:2 and 2:2 cells) gives the same product as a build with `USE_42=0` (3:2 and 2:2 cells only), for every input.
- R5: With `PIPE=1`, a rising clock edge with `en_i=1` captures the compressed rows. `prod_o` then shows the product of the inputs present at that edge, one cycle of latency.
- R6: With `PIPE=1`, an edge with `en_i=0` leaves `prod_o` unchanged, even when the inputs change.
- R7: With `PIPE=1`, `prod_o` is 0 while `rst_ni` is low, without waiting for a clock edge.
- R8: With `PIPE=0`, `prod_o` follows the inputs combinationally and ignores the clock and enable.
- R9: Extreme operands give exact results. Most-negative times most-negative (signed) gives 2^(A_W+B_W-2). All-ones times all-ones (unsigned) gives (2^A_W-1)(2^B_W-1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the optional register stage |
| rst_ni | input | 1 | Active-low asynchronous reset of the register stage |
| en_i | input | 1 | Capture enable of the register stage |
| a_i | input | A_W | Multiplicand |
| b_i | input | B_W | Multiplier |
| a_sgn_i | input | 1 | Runtime signedness of `a_i` (1 = signed), used when `A_SEL_EN=1` |
| b_sgn_i | input | 1 | Runtime signedness of `b_i` (1 = signed), used when `B_SEL_EN=1` |
| prod_o | output | A_W+B_W | Product |

## Verification
The bench goes after the most-negative operands in every signedness mix. A wrong sign extension of the partial products shows up there as a product off by a power-of-two multiple of the other operand. It also uses all-ones unsigned operands, where a carry dropped from a high column or a wrongly discarded carry out of the top column corrupts the upper bits. Builds with and without 4:2 cells get the same random and directed vectors, so a lost or misrouted horizontal carry appears as a mismatch in one build only. Enable-low cycles with changing inputs, and a reset asserted between edges, expose a register stage that loads when it should hold or that resets only on a clock edge. A static-sign build with its select inputs toggled shows whether a select leaks through when it should be ignored.

// File: rtl/cmul_pkg.sv
package cmul_pkg;
  // {carry, sum} of three bits
  function automatic logic [1:0] fa3(input logic x, input logic y, input logic z);
    return {(x & y) | (z & (x | y)), x ^ y ^ z};
  endfunction
endpackage

// File: rtl/cmul_ppgen.sv
module cmul_ppgen #(
  parameter int A_W = 8,
  parameter int B_W = 8,
  localparam int P = A_W + B_W
) (
  input  logic [A_W-1:0]        a_i,
  input  logic [B_W-1:0]        b_i,
  input  logic                  a_s_i,
  input  logic                  b_s_i,
  output logic [P-1:0][P-1:0]   pp_o   // pp_o[row][column]
);
  logic [P-1:0] a_ext, b_ext;
  assign a_ext = {{B_W{a_s_i & a_i[A_W-1]}}, a_i};
  assign b_ext = {{A_W{b_s_i & b_i[B_W-1]}}, b_i};

  for (genvar j = 0; j < P; j++) begin : g_row
    for (genvar c = 0; c < P; c++) begin : g_col
      if (c >= j) begin : g_bit
        assign pp_o[j][c] = a_ext[c-j] & b_ext[j];
      end else begin : g_zero
        assign pp_o[j][c] = 1'b0;
      end
    end
  end

  always_comb begin
    if (!$isunknown({a_i, b_i})) begin
      // R1
      zero_op_chk: assert (!((a_i == '0) || (b_i == '0)) || (pp_o == '0))
        else $error("partial products nonzero for zero operand");
    end
  end
endmodule

// File: rtl/cmul_colred.sv
module cmul_colred
  import cmul_pkg::*;
#(
  parameter int P      = 16,
  parameter bit USE_42 = 1'b1,
  localparam int D = 3 * P + 4
) (
  input  logic [P-1:0][P-1:0] pp_i,
  output logic [P-1:0]        row0_o,
  output logic [P-1:0]        row1_o
);
  logic [D-1:0] ord_b [P];   // ordinary terms per column
  logic [D-1:0] car_b [P];   // horizontal carries per column
  int           n_o   [P];
  int           n_c   [P];
  logic [3:0]   t;
  logic         cin, s1, c1, s, cy;
  logic [1:0]   r;
  int           nin;

  always_comb begin
    t = '0; cin = 1'b0; s1 = 1'b0; c1 = 1'b0; s = 1'b0; cy = 1'b0; r = '0; nin = 0;
    for (int c = 0; c < P; c++) begin
      ord_b[c] = '0;
      car_b[c] = '0;
      n_o[c]   = c + 1;
      n_c[c]   = 0;
      for (int j = 0; j < P; j++)
        if (j <= c) ord_b[c][j] = pp_i[j][c];
    end
    // sweep low to high; carries land in columns not yet reduced
    for (int c = 0; c < P; c++) begin
      for (int k = 0; k < D; k++) begin
        if (n_o[c] + n_c[c] > 2) begin
          if (USE_42 && (n_o[c] + n_c[c] > 4)) nin = 4;
          else if (n_o[c] + n_c[c] > 3)        nin = 3;
          else                                 nin = 2;
          t = '0;
          for (int q = 0; q < 4; q++) begin
            if (q < nin) begin
              if (n_o[c] > 0) begin
                t[q] = ord_b[c][n_o[c]-1];
                n_o[c] = n_o[c] - 1;
              end else begin
                t[q] = car_b[c][n_c[c]-1];
                n_c[c] = n_c[c] - 1;
              end
            end
          end
          c1 = 1'b0;
          if (nin == 4) begin
            cin = 1'b0;
            if (n_c[c] > 0) begin
              cin = car_b[c][n_c[c]-1];
              n_c[c] = n_c[c] - 1;
            end
            r = fa3(t[1], t[2], t[3]);
            s1 = r[0]; c1 = r[1];
            r = fa3(s1, t[0], cin);
          end else if (nin == 3) begin
            r = fa3(t[0], t[1], t[2]);
          end else begin
            r = {t[0] & t[1], t[0] ^ t[1]};
          end
          s = r[0]; cy = r[1];
          ord_b[c][n_o[c]] = s;
          n_o[c] = n_o[c] + 1;
          if (c < P - 1) begin
            ord_b[c+1][n_o[c+1]] = cy;
            n_o[c+1] = n_o[c+1] + 1;
            if (nin == 4) begin
              car_b[c+1][n_c[c+1]] = c1;
              n_c[c+1] = n_c[c+1] + 1;
            end
          end
        end
      end
    end
    // read out: horizontal carries ahead of ordinary terms
    for (int c = 0; c < P; c++) begin
      if (n_c[c] > 0)      row0_o[c] = car_b[c][0];
      else if (n_o[c] > 0) row0_o[c] = ord_b[c][0];
      else                 row0_o[c] = 1'b0;
      if (n_c[c] > 1)       row1_o[c] = car_b[c][1];
      else if (n_c[c] == 1) row1_o[c] = (n_o[c] > 0) ? ord_b[c][0] : 1'b0;
      else                  row1_o[c] = (n_o[c] > 1) ? ord_b[c][1] : 1'b0;
    end
  end

  logic [P-1:0] pp_sum;
  always_comb begin
    pp_sum = '0;
    for (int j = 0; j < P; j++) pp_sum = pp_sum + pp_i[j];
    if (!$isunknown(pp_i)) begin
      // R4
      rows_keep_sum_chk: assert (P'(row0_o + row1_o) == pp_sum)
        else $error("compressed rows lost value");
    end
  end
endmodule

// File: rtl/cmul_cpa.sv
module cmul_cpa #(
  parameter int P = 16
) (
  input  logic [P-1:0] x_i,
  input  logic [P-1:0] y_i,
  output logic [P-1:0] s_o
);
  logic [P:0] c;
  assign c[0] = 1'b0;
  for (genvar i = 0; i < P; i++) begin : g_rip
    assign s_o[i]   = x_i[i] ^ y_i[i] ^ c[i];
    assign c[i+1]   = (x_i[i] & y_i[i]) | (c[i] & (x_i[i] ^ y_i[i]));
  end
endmodule

// File: rtl/cmul_top.sv
module cmul_top #(
  parameter int A_W      = 8,
  parameter int B_W      = 8,
  parameter bit A_SIGNED = 1'b0,
  parameter bit B_SIGNED = 1'b0,
  parameter bit A_SEL_EN = 1'b1,
  parameter bit B_SEL_EN = 1'b1,
  parameter bit USE_42   = 1'b1,
  parameter bit PIPE     = 1'b1,
  localparam int P = A_W + B_W
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           en_i,
  input  logic [A_W-1:0] a_i,
  input  logic [B_W-1:0] b_i,
  input  logic           a_sgn_i,
  input  logic           b_sgn_i,
  output logic [P-1:0]   prod_o
);
  logic                a_s, b_s;
  logic [P-1:0][P-1:0] pp;
  logic [P-1:0]        t0, t1, r0, r1;

  assign a_s = A_SEL_EN ? a_sgn_i : A_SIGNED;
  assign b_s = B_SEL_EN ? b_sgn_i : B_SIGNED;

  cmul_ppgen #(.A_W(A_W), .B_W(B_W)) u_pp (
    .a_i(a_i), .b_i(b_i), .a_s_i(a_s), .b_s_i(b_s), .pp_o(pp));

  cmul_colred #(.P(P), .USE_42(USE_42)) u_red (
    .pp_i(pp), .row0_o(t0), .row1_o(t1));

  if (PIPE) begin : g_pipe
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        r0 <= '0;
        r1 <= '0;
      end else if (en_i) begin
        r0 <= t0;
        r1 <= t1;
      end
    end
  end else begin : g_comb
    assign r0 = t0;
    assign r1 = t1;
  end

  cmul_cpa #(.P(P)) u_cpa (.x_i(r0), .y_i(r1), .s_o(prod_o));

  // independent reference for checking
  logic signed [P:0] ax, bx, pr;
  assign ax = a_s ? (P+1)'($signed(a_i)) : (P+1)'($unsigned(a_i));
  assign bx = b_s ? (P+1)'($signed(b_i)) : (P+1)'($unsigned(b_i));
  assign pr = ax * bx;

  always_comb begin
    if (!$isunknown({a_i, b_i, a_s, b_s})) begin
      // R1
      tree_prod_chk: assert (P'(t0 + t1) == pr[P-1:0])
        else $error("tree product mismatch");
    end
  end

  if (PIPE) begin : g_pipe_chk
    // R5
    latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      en_i |=> (prod_o == $past(pr[P-1:0])))
      else $error("pipelined product wrong");
    // R6
    hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i |=> $stable(prod_o))
      else $error("product moved with enable low");
  end
endmodule

// File: tb/cmul_top_tb.sv
`timescale 1ns/1ps
module cmul_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_ni;
  logic       en;
  logic [7:0] a, b;
  logic       as_, bs_;
  logic [15:0] prod_p, prod_c;
  logic [5:0] sa;
  logic [4:0] sb;
  logic       ssa, ssb;
  logic [10:0] prod_s;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  cmul_top #(.A_W(8), .B_W(8), .USE_42(1'b1), .PIPE(1'b1)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en), .a_i(a), .b_i(b),
    .a_sgn_i(as_), .b_sgn_i(bs_), .prod_o(prod_p));

  cmul_top #(.A_W(8), .B_W(8), .USE_42(1'b0), .PIPE(1'b0)) dut_c_i (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en), .a_i(a), .b_i(b),
    .a_sgn_i(as_), .b_sgn_i(bs_), .prod_o(prod_c));

  cmul_top #(.A_W(6), .B_W(5), .A_SIGNED(1'b1), .B_SIGNED(1'b0),
             .A_SEL_EN(1'b0), .B_SEL_EN(1'b0), .USE_42(1'b1), .PIPE(1'b0)) dut_s_i (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en), .a_i(sa), .b_i(sb),
    .a_sgn_i(ssa), .b_sgn_i(ssb), .prod_o(prod_s));

  function automatic longint ref_mul(input longint x, input longint y,
                                     input bit xs, input bit ys,
                                     input int xw, input int yw);
    longint xe, ye;
    xe = (xs && x[xw-1]) ? x - (longint'(1) << xw) : x;
    ye = (ys && y[yw-1]) ? y - (longint'(1) << yw) : y;
    return (xe * ye) & ((longint'(1) << (xw + yw)) - 1);
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive at negedge, capture at posedge, sample at next negedge
  task automatic vec(input logic [7:0] xa, input logic [7:0] xb,
                     input bit xs, input bit ys, input string req);
    longint e;
    @(negedge clk);
    a = xa; b = xb; as_ = xs; bs_ = ys; en = 1'b1;
    e = ref_mul(xa, xb, xs, ys, 8, 8);
    @(negedge clk);
    chk({req, " R5 pipe"}, prod_p, e);
    chk({req, " R4 R8 comb"}, prod_c, e);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    longint e_old, e_new;
    void'($urandom(32'd1234));
    rst_ni = 1'b0; en = 1'b1; a = 8'h7f; b = 8'h33; as_ = 1'b0; bs_ = 1'b0;
    sa = '0; sb = '0; ssa = 1'b0; ssb = 1'b0;
    repeat (3) @(negedge clk);
    chk("R7 reset with enable high", prod_p, 0);
    @(negedge clk);
    rst_ni = 1'b1;

    // R1 all four signedness mixes on negative-looking operands
    for (int m = 0; m < 4; m++) begin
      vec(8'hc5, 8'h9e, m[0], m[1], "R1 R2 R3 mix");
      vec(8'h80, 8'h80, m[0], m[1], "R9 min*min mix");
    end
    // R9 extremes
    vec(8'h80, 8'h80, 1'b1, 1'b1, "R9 min*min signed");
    chk("R9 min*min value", prod_p, 64'h4000);
    vec(8'hff, 8'hff, 1'b0, 1'b0, "R9 ones unsigned");
    chk("R9 ones value", prod_p, 64'hfe01);
    vec(8'h7f, 8'h80, 1'b1, 1'b1, "R9 max*min");
    vec(8'h00, 8'hff, 1'b1, 1'b1, "R1 zero");
    vec(8'h01, 8'hff, 1'b1, 1'b1, "R1 one*-1");

    // random
    for (int i = 0; i < 300; i++)
      vec(8'($urandom), 8'($urandom), 1'($urandom), 1'($urandom), "R1 random");

    // R6 hold with enable low while inputs change
    vec(8'h5a, 8'hc3, 1'b1, 1'b0, "R6 setup");
    e_old = ref_mul(8'h5a, 8'hc3, 1'b1, 1'b0, 8, 8);
    @(negedge clk);
    en = 1'b0; a = 8'h91; b = 8'h17; as_ = 1'b0; bs_ = 1'b1;
    e_new = ref_mul(8'h91, 8'h17, 1'b0, 1'b1, 8, 8);
    @(negedge clk);
    chk("R6 hold", prod_p, e_old);
    chk("R8 comb ignores enable", prod_c, e_new);
    @(negedge clk);
    chk("R6 hold second edge", prod_p, e_old);
    en = 1'b1;
    @(negedge clk);
    chk("R5 reload", prod_p, e_new);

    // R7 asynchronous reset between edges
    #3 rst_ni = 1'b0;
    #2 chk("R7 async reset", prod_p, 0);
    chk("R8 comb during reset", prod_c, e_new);
    @(negedge clk);
    rst_ni = 1'b1;

    // static-sign build: selects must be ignored
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      sa = 6'($urandom); sb = 5'($urandom);
      if (i < 4) begin sa = 6'h20; sb = 5'h1f; end
      ssa = 1'b0; ssb = 1'b1;
      #2 chk("R2 R3 static signs sel=01", prod_s, ref_mul(sa, sb, 1'b1, 1'b0, 6, 5));
      ssa = 1'b1; ssb = 1'b0;
      #2 chk("R2 R3 static signs sel=10", prod_s, ref_mul(sa, sb, 1'b1, 1'b0, 6, 5));
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule